// File: doc/BRIEF.md
# Board Address Decoder with Boot Redirect

This block is the address-decoding glue of a small 8-bit computer board with a 16-bit CPU address bus. From the CPU address and the read/write strobe it produces one chip select per device: the low program RAM, the monitor ROM, the interrupt-vector RAM in the top page, eight parallel-interface adapters and one timer/I/O device. Devices that use only some of the address bits appear at several aliased addresses.

The vector RAM holds nothing useful at power-up. While reset is active, and up to the first clock edge after reset is released, the block therefore drives the most significant address bit seen by the memories low. The CPU's reset-vector fetch from the top of the map then lands in the ROM, which holds a valid start address. A single register holds this override; everything else is combinational.

The adapter register select, the timer register select and the timer's interrupt-enable bit are passed straight through from the low address bits.

Top module: `board_addr_decode`

## Requirements
- R1: `selRam` is 1 exactly when the effective address lies in 0x0000–0x01FF, for reads and for writes.
- R2: `selRom` is 1 exactly when the effective address lies in 0x7C00–0x7FFF and `cpuRw` is 1 (read). A write there selects nothing and raises `unmapped`.
- R3: `selVec` is 1 exactly when the effective address lies in 0xFFC0–0xFFFF.
- R4: `selPia[k]` is 1 exactly for effective addresses 0x4000+4k to 0x4003+4k, for k = 0..7, so k is address bits 4:2. `piaReg` always equals address bits 1:0.
- R5: `selTim` is 1 when address bits 15:12 are 0x6 and bits 9:4 are 0x20, whatever bits 11 and 10 hold. The device therefore appears at 0x620x, 0x660x, 0x6A0x and 0x6E0x. `timReg` always equals address bits 2:0, and `timIntEn` always equals address bit 3, so adding 0x0008 picks the interrupt-enabled variant.
- R6: At most one of the 12 select outputs is 1 at a time. `unmapped` is 1 exactly when none is.
- R7: While `rstN` is 0, `effA15` is 0 and decoding uses it in place of address bit 15, so a read of 0xFFFC or 0xFFFD selects the ROM. Once the override has cleared, `effA15` equals address bit 15.
- R8: The override stays active after `rstN` rises, up to the first rising clock edge. From that edge on it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the override register |
| rstN | input | 1 | Active-low reset; sets the override asynchronously |
| cpuAddr | input | 16 | CPU address bus |
| cpuRw | input | 1 | 1 = read cycle, 0 = write cycle |
| selRam | output | 1 | Program RAM select |
| selRom | output | 1 | Monitor ROM select |
| selVec | output | 1 | Interrupt-vector RAM select |
| selPia | output | 8 | One-hot interface adapter selects |
| selTim | output | 1 | Timer/I/O device select |
| unmapped | output | 1 | No device decoded |
| effA15 | output | 1 | Effective address bit 15 driven to the memories |
| piaReg | output | 2 | Adapter register select |
| timReg | output | 3 | Timer register select |
| timIntEn | output | 1 | Timer interrupt-enable variant |

## Verification
All selects and pass-through fields follow the address and `cpuRw` combinationally, in the same cycle. The bench drives each stimulus at the falling edge and compares a quarter period later, before the next rising edge can move the override. The override is the one registered result. Release of `rstN` is placed at a falling edge, and a reset-vector read is checked once before the next rising edge, where it must still hit the ROM (R8). It is checked again one cycle later, where it must hit the vector RAM. The full 65536-address sweeps run one address per cycle, with reset held and with reset released, and each expected item enters the scoreboard queue in the cycle its address is applied.

// File: rtl/board_addr_decode_pkg.sv
package board_addr_decode_pkg;

  // Strobes from the control part to the decode datapath.
  typedef struct packed {
    logic forceLow;   // drive effective A15 to zero
    logic isRead;     // current bus cycle is a read
  } ctrlStrobes_t;

endpackage

// File: rtl/board_addr_decode_ctrl.sv
module board_addr_decode_ctrl
  import board_addr_decode_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuRw,
  output ctrlStrobes_t ctrl
);

  logic overrideQ;

  // Set while reset is held; cleared by the first edge after release.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrideQ <= 1'b1;
    else       overrideQ <= 1'b0;
  end

  always_comb begin
    ctrl.forceLow = overrideQ;
    ctrl.isRead   = cpuRw;
  end

  AST_OVR_HELD_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> overrideQ) else $error("override dropped early"); // R8
  AST_OVR_CLEARS_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |=> !overrideQ) else $error("override stuck"); // R8

endmodule

// File: rtl/board_addr_decode_dp.sv
module board_addr_decode_dp
  import board_addr_decode_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int RAM_BYTES   = 512,
  parameter int ROM_BYTES   = 1024,
  parameter int ROM_BASE    = 'h7C00,
  parameter int VEC_BYTES   = 64,
  parameter int PIA_CNT     = 8,
  parameter int PIA_REGS    = 4,
  parameter int PIA_BASE    = 'h4000,
  parameter int TIM_REGS    = 16,
  parameter int TIM_BASE    = 'h6200,
  parameter int TIM_IGNORE  = 'h0C00,
  localparam int PIA_REG_W  = $clog2(PIA_REGS),
  localparam int PIA_IDX_W  = $clog2(PIA_CNT),
  localparam int TIM_IE_BIT = $clog2(TIM_REGS) - 1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  ctrlStrobes_t         ctrl,
  output logic                 selRam,
  output logic                 selRom,
  output logic                 selVec,
  output logic [PIA_CNT-1:0]   selPia,
  output logic                 selTim,
  output logic                 unmapped,
  output logic                 effMsb,
  output logic [PIA_REG_W-1:0] piaReg,
  output logic [TIM_IE_BIT-1:0] timReg,
  output logic                 timIntEn
);

  localparam int PIA_SPAN = PIA_CNT * PIA_REGS;
  localparam logic [ADDR_W-1:0] ROM_MASK  = ~ADDR_W'(ROM_BYTES - 1);
  localparam logic [ADDR_W-1:0] ROM_B     = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] VEC_MASK  = ~ADDR_W'(VEC_BYTES - 1);
  localparam logic [ADDR_W-1:0] PIA_MASK  = ~ADDR_W'(PIA_SPAN - 1);
  localparam logic [ADDR_W-1:0] PIA_B     = ADDR_W'(PIA_BASE);
  localparam logic [ADDR_W-1:0] TIM_IGN   = ADDR_W'(TIM_IGNORE);
  localparam logic [ADDR_W-1:0] TIM_MASK  = ~ADDR_W'(TIM_REGS - 1);
  localparam logic [ADDR_W-1:0] TIM_KEY   = ADDR_W'(TIM_BASE) | TIM_IGN;
  localparam logic [ADDR_W-1:0] RAM_LIMIT = ADDR_W'(RAM_BYTES);

  logic [ADDR_W-1:0]    effAddr;
  logic                 inPia;
  logic [PIA_IDX_W-1:0] piaIdx;

  // Effective address seen by the memories.
  assign effMsb  = cpuAddr[ADDR_W-1] & ~ctrl.forceLow;
  assign effAddr = {effMsb, cpuAddr[ADDR_W-2:0]};

  assign selRam = effAddr < RAM_LIMIT;
  assign selRom = ((effAddr & ROM_MASK) == ROM_B) && ctrl.isRead;
  assign selVec = (effAddr & VEC_MASK) == VEC_MASK;
  assign selTim = ((effAddr | TIM_IGN) & TIM_MASK) == TIM_KEY;
  assign inPia  = (effAddr & PIA_MASK) == PIA_B;
  assign piaIdx = effAddr[PIA_REG_W +: PIA_IDX_W];

  for (genvar k = 0; k < PIA_CNT; k++) begin : g_pia
    assign selPia[k] = inPia && (piaIdx == PIA_IDX_W'(k));
  end

  assign unmapped = ~(selRam | selRom | selVec | selTim | (|selPia));
  assign piaReg   = effAddr[PIA_REG_W-1:0];
  assign timReg   = effAddr[TIM_IE_BIT-1:0];
  assign timIntEn = effAddr[TIM_IE_BIT];

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selRam, selRom, selVec, selTim, selPia})) else $error("select clash"); // R6
  AST_NO_ROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.isRead |-> !selRom) else $error("rom selected on write"); // R2
  AST_VEC_NEEDS_MSB: assert property (@(posedge clk) disable iff (!rstN)
    selVec |-> cpuAddr[ADDR_W-1]) else $error("vec without msb"); // R3

endmodule

// File: rtl/board_addr_decode.sv
module board_addr_decode
  import board_addr_decode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic        cpuRw,
  output logic        selRam,
  output logic        selRom,
  output logic        selVec,
  output logic [7:0]  selPia,
  output logic        selTim,
  output logic        unmapped,
  output logic        effA15,
  output logic [1:0]  piaReg,
  output logic [2:0]  timReg,
  output logic        timIntEn
);

  ctrlStrobes_t ctrl;

  board_addr_decode_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .cpuRw (cpuRw),
    .ctrl  (ctrl)
  );

  board_addr_decode_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cpuAddr  (cpuAddr),
    .ctrl     (ctrl),
    .selRam   (selRam),
    .selRom   (selRom),
    .selVec   (selVec),
    .selPia   (selPia),
    .selTim   (selTim),
    .unmapped (unmapped),
    .effMsb   (effA15),
    .piaReg   (piaReg),
    .timReg   (timReg),
    .timIntEn (timIntEn)
  );

  AST_FORCE_BLOCKS_VEC: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.forceLow |-> (!selVec && !effA15)) else $error("vector ram reachable in override"); // R7

endmodule

// File: tb/board_addr_decode_tb.sv
module board_addr_decode_tb_top;

  localparam int CLK_P = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  typedef struct {
    logic [19:0] vec;
    logic [15:0] addr;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuRw = 1'b1;
  logic        selRam, selRom, selVec, selTim, unmapped, effA15, timIntEn;
  logic [7:0]  selPia;
  logic [1:0]  piaReg;
  logic [2:0]  timReg;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  expItem_t sbQueue[$];

  always #(CLK_P/2) clk = ~clk;

  board_addr_decode dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRw(cpuRw),
    .selRam(selRam), .selRom(selRom), .selVec(selVec), .selPia(selPia),
    .selTim(selTim), .unmapped(unmapped), .effA15(effA15),
    .piaReg(piaReg), .timReg(timReg), .timIntEn(timIntEn)
  );

  // Reference map written from the requirements.
  function automatic expItem_t refModel(input logic [15:0] a, input logic rd,
                                        input logic forced);
    expItem_t e;
    logic [15:0] ea;
    logic ram, rom, vec, tim, unm;
    logic [7:0] pia;
    ea  = {forced ? 1'b0 : a[15], a[14:0]};
    ram = ea <= 16'h01FF;                              // R1
    rom = (ea >= 16'h7C00) && (ea <= 16'h7FFF) && rd;  // R2
    vec = ea >= 16'hFFC0;                              // R3
    pia = '0;
    if (ea >= 16'h4000 && ea <= 16'h401F) pia[ea[4:2]] = 1'b1; // R4
    tim = (ea[15:12] == 4'h6) && (ea[9:4] == 6'h20);   // R5
    unm = !(ram || rom || vec || tim || (pia != 0));   // R6
    e.vec  = {ram, rom, vec, pia, tim, unm, ea[15], a[1:0], a[2:0], a[3]};
    e.addr = a;
    if (forced && a[15])  e.tag = "R7";
    else if (ram)         e.tag = "R1";
    else if (rom)         e.tag = "R2";
    else if (vec)         e.tag = "R3";
    else if (pia != 0)    e.tag = "R4";
    else if (tim)         e.tag = "R5";
    else                  e.tag = "R6";
    return e;
  endfunction

  // Driver: apply stimulus at the falling edge and queue the expectation.
  task automatic drive(input logic [15:0] a, input logic rd, input logic forced,
                       input string tagOverride);
    expItem_t e;
    @(negedge clk);
    cpuAddr = a;
    cpuRw   = rd;
    e = refModel(a, rd, forced);
    if (tagOverride != "") e.tag = tagOverride;
    sbQueue.push_back(e);
  endtask

  // Monitor: compare a quarter period after each falling edge.
  always @(negedge clk) begin
    expItem_t e;
    logic [19:0] got;
    #(CLK_P/4);
    if (sbQueue.size() > 0) begin
      e = sbQueue.pop_front();
      got = {selRam, selRom, selVec, selPia, selTim, unmapped, effA15,
             piaReg, timReg, timIntEn};
      testsRun++;
      if (got !== e.vec) begin
        testsFailed++;
        $display("FAIL %s addr=%h rw=%b actual=%b expected=%b",
                 e.tag, e.addr, cpuRw, got, e.vec);
      end
    end
  end

  initial begin
    // Reset held: whole map decoded with effective A15 forced low (R7).
    for (int a = 0; a < 65536; a++) drive(16'(a), 1'b1, 1'b1, "");
    drive(16'hFFFC, 1'b1, 1'b1, "R7");
    drive(16'hFFFD, 1'b1, 1'b1, "R7");
    // Release at a falling edge; before the next rising edge still redirected (R8).
    @(negedge clk);
    rstN = 1'b1;
    cpuAddr = 16'hFFFC;
    cpuRw = 1'b1;
    sbQueue.push_back(refModel(16'hFFFC, 1'b1, 1'b1));
    sbQueue[sbQueue.size()-1].tag = "R8";
    // After the first rising edge the override is gone (R8).
    drive(16'hFFFC, 1'b1, 1'b0, "R8");
    drive(16'hFFFD, 1'b1, 1'b0, "R8");
    // Normal operation, reads over the whole map (R1..R6 aliases included).
    for (int a = 0; a < 65536; a++) drive(16'(a), 1'b1, 1'b0, "");
    // Writes into the ROM window select nothing (R2).
    for (int a = 16'h7C00; a <= 16'h7FFF; a++) drive(16'(a), 1'b0, 1'b0, "R2");
    // Writes reach RAM, vector RAM, adapters and timer aliases.
    drive(16'h01FF, 1'b0, 1'b0, "R1");
    drive(16'h0200, 1'b0, 1'b0, "R1");
    drive(16'hFFC0, 1'b0, 1'b0, "R3");
    drive(16'h401D, 1'b0, 1'b0, "R4");
    drive(16'h6E0B, 1'b0, 1'b0, "R5");
    drive(16'h6A07, 1'b0, 1'b0, "R5");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!finished && cycles < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
    end
    #(CLK_P);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule